// File: doc/BRIEF.md
# Interrupt Pin Service Unit

This block sits behind every input pin of an interrupt router. It remembers each pin's request state and, using that pin's routing entry (vector, destination, trigger type, mask), decides when a delivery request goes out. Requests leave one at a time through a valid/ready handshake. A separate input reports whether at least one destination took the interrupt. Edge-type pins deliver once per assertion. A level-type pin is blocked by its remote-IRR flag after an accepted delivery. A level-type end-of-interrupt (EOI) carrying the pin's vector releases it again.

A level pin that stays asserted can be re-delivered on every EOI without pause. To stop such a storm, a per-pin counter tracks back-to-back EOI re-deliveries. When the counter reaches its limit, the next re-delivery is held back for a programmable number of cycles. When that time runs out, every level pin that still has a request and a clear remote-IRR gets served. Routing of the request to a destination is done elsewhere.

Top module: `irq_pin_service`

## Requirements
- R1: After reset no delivery request is presented, all remote-IRR flags read 0 and no deferral is running.
- R2: A pin's request bit follows the pin level. A 0-to-1 change schedules one service attempt. A pin held high schedules nothing more (coalesced), and a new attempt needs the pin to go low and rise again.
- R3: A service attempt is discarded, not retried later, when the entry is masked, when it is level-type with remote-IRR set, or when it is level-type and its pin has gone low. No request is ever presented for such an entry.
- R4: A handshake (dlv_valid and dlv_ready both 1) with dlv_accepted=1 on a level-type entry sets that pin's remote-IRR on the next cycle. With dlv_accepted=0 the flag stays 0. Remote-IRR of an edge-type entry (ent_lvl=0) always reads 0.
- R5: An EOI with eoi_lvl=1 clears remote-IRR of every level-type entry whose vector equals eoi_vector. An EOI with eoi_lvl=0, or with a vector that no entry holds, changes nothing.
- R6: If such an EOI finds the entry unmasked and its request bit set, the pin is served again, with the handshake one cycle after the EOI cycle.
- R7: Each pin's storm counter rises by one on every EOI re-service and returns to 0 in any cycle where the pin is masked or its request bit is clear.
- R8: The EOI re-service that would bring the counter to STORM_LIMIT is not delivered. Instead the counter returns to 0 and a deferral of DEFER_CYCLES cycles starts. No request comes from that pin before the deferral ends.
- R9: When the deferral ends, every level-type pin with its request set and remote-IRR clear gets one service attempt, still subject to R3. Edge-type pins are not served.
- R10: When several pins wait, the lowest pin index is presented first. dlv_pin, dlv_vector, dlv_dest and dlv_lvl carry that pin's index and entry fields. Only one pin is delivered per handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Current level of each interrupt pin |
| ent_mask | input | NPINS | Entry mask per pin, 1 = masked |
| ent_lvl | input | NPINS | Entry trigger type, 1 = level, 0 = edge |
| ent_vector | input | NPINS*VEC_W | Entry vectors, pin i at bits [i*VEC_W +: VEC_W] |
| ent_dest | input | NPINS*DEST_W | Entry destinations, pin i at bits [i*DEST_W +: DEST_W] |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | Delivery request taken this cycle |
| dlv_accepted | input | 1 | At handshake: at least one destination accepted |
| dlv_pin | output | IDX_W | Index of the pin being delivered |
| dlv_vector | output | VEC_W | Vector of the delivered entry |
| dlv_dest | output | DEST_W | Destination of the delivered entry |
| dlv_lvl | output | 1 | Trigger type of the delivered entry |
| eoi_valid | input | 1 | EOI event this cycle |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_lvl | input | 1 | EOI type, 1 = level |
| remote_irr | output | NPINS | Remote-IRR flag per pin |

## Verification
An EOI that releases one pin can arrive in the same cycle as the handshake that delivers another pin. In that cycle the block both sets one remote-IRR and clears a different one, and it both retires one pending service and schedules a new one. The bench sets this up by holding a level pin blocked on remote-IRR and stalling dlv_ready while a second level pin waits. It then raises dlv_ready and issues the first pin's EOI in the same cycle. It checks that both pins end with one more delivery, that both remote-IRR flags are set, and that the waiting pin went out before the released one.

// File: rtl/irq_pin_service.sv
module irq_pin_service #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 1000000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPINS-1:0]          pin_level,
  input  logic [NPINS-1:0]          ent_mask,
  input  logic [NPINS-1:0]          ent_lvl,
  input  logic [NPINS*VEC_W-1:0]    ent_vector,
  input  logic [NPINS*DEST_W-1:0]   ent_dest,
  output logic                      dlv_valid,
  input  logic                      dlv_ready,
  input  logic                      dlv_accepted,
  output logic [(NPINS>1 ? $clog2(NPINS) : 1)-1:0] dlv_pin,
  output logic [VEC_W-1:0]          dlv_vector,
  output logic [DEST_W-1:0]         dlv_dest,
  output logic                      dlv_lvl,
  input  logic                      eoi_valid,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic                      eoi_lvl,
  output logic [NPINS-1:0]          remote_irr
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1);

  logic [NPINS-1:0] req_q, pend_q, rirr_q;
  logic [NPINS-1:0] elig, want, grant_1h, taken;
  logic [NPINS-1:0] eoi_hit, resvc_try, storm_hit, eoi_resvc, expire_set;
  logic [CNT_W-1:0] cnt_q [NPINS];
  logic             defer_q, expire, hs;
  logic [TMR_W-1:0] tmr_q;
  logic [IDX_W-1:0] sel;

  // A pending attempt survives only while the entry could legally be served.
  assign elig     = ~ent_mask & ~(ent_lvl & rirr_q) & (~ent_lvl | req_q);
  assign want     = pend_q & elig;
  assign grant_1h = want & (~want + NPINS'(1));
  assign dlv_valid = |want;
  assign hs       = dlv_valid & dlv_ready;
  assign taken    = hs ? grant_1h : '0;

  always_comb begin
    sel = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (want[i]) sel = IDX_W'(i);
  end

  assign dlv_pin    = sel;
  assign dlv_vector = ent_vector[sel*VEC_W +: VEC_W];
  assign dlv_dest   = ent_dest[sel*DEST_W +: DEST_W];
  assign dlv_lvl    = ent_lvl[sel];
  assign remote_irr = rirr_q;

  assign expire     = defer_q && (tmr_q == TMR_W'(DEFER_CYCLES - 1));
  assign expire_set = {NPINS{expire}} & ent_lvl & req_q & ~rirr_q;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      assign eoi_hit[g]   = eoi_valid & eoi_lvl & ent_lvl[g] &
                            (ent_vector[g*VEC_W +: VEC_W] == eoi_vector);
      assign resvc_try[g] = eoi_hit[g] & ~ent_mask[g] & req_q[g];
      assign storm_hit[g] = resvc_try[g] & (cnt_q[g] == CNT_W'(STORM_LIMIT - 1));
      assign eoi_resvc[g] = resvc_try[g] & ~storm_hit[g];

      always_ff @(posedge clk) begin
        if (!rst_n)                                 cnt_q[g] <= '0;
        else if (ent_mask[g] || !req_q[g] || storm_hit[g]) cnt_q[g] <= '0;
        else if (resvc_try[g])                      cnt_q[g] <= cnt_q[g] + CNT_W'(1);
      end

      assert_rirr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dlv_valid && dlv_ready && dlv_accepted && dlv_lvl && dlv_pin == IDX_W'(g) && ent_lvl[g])
          |=> remote_irr[g]);

      assert_rirr_origin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(remote_irr[g]) |->
          $past(dlv_valid && dlv_ready && dlv_accepted && dlv_pin == IDX_W'(g)));

      assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_lvl && ent_lvl[g] && ent_vector[g*VEC_W +: VEC_W] == eoi_vector &&
         !(dlv_valid && dlv_ready && dlv_pin == IDX_W'(g)))
          |=> !remote_irr[g]);

      assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q[g] < CNT_W'(STORM_LIMIT));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      rirr_q  <= '0;
      defer_q <= 1'b0;
      tmr_q   <= '0;
    end else begin
      req_q  <= pin_level;
      pend_q <= (pend_q & elig & ~taken) | (pin_level & ~req_q) | eoi_resvc | expire_set;
      rirr_q <= ((rirr_q & ~eoi_hit) | (dlv_accepted && dlv_lvl ? taken : '0)) & ent_lvl;
      if (expire) begin
        defer_q <= 1'b0;
        tmr_q   <= '0;
      end else if (defer_q) begin
        tmr_q   <= tmr_q + TMR_W'(1);
      end else if (|storm_hit) begin
        defer_q <= 1'b1;
        tmr_q   <= '0;
      end
    end
  end

  assert_never_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> (!ent_mask[dlv_pin] && !(ent_lvl[dlv_pin] && remote_irr[dlv_pin])));
endmodule

// File: tb/irq_pin_service_tb.sv
module irq_pin_service_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int DEF = 20;
  localparam int LIM = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_level, ent_mask, ent_lvl, remote_irr;
  logic [NP*8-1:0] ent_vector;
  logic [NP*4-1:0] ent_dest;
  logic dlv_valid, dlv_ready, dlv_accepted, dlv_lvl;
  logic [1:0] dlv_pin;
  logic [7:0] dlv_vector;
  logic [3:0] dlv_dest;
  logic eoi_valid, eoi_lvl;
  logic [7:0] eoi_vector;

  int tests = 0, fails = 0;
  int dcnt [NP];
  int lastvec [NP];
  int lastdest [NP];
  int ord [64];
  int ord_n = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_pin_service #(.NPINS(NP), .VEC_W(8), .DEST_W(4), .STORM_LIMIT(LIM), .DEFER_CYCLES(DEF)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .ent_mask(ent_mask), .ent_lvl(ent_lvl),
    .ent_vector(ent_vector), .ent_dest(ent_dest), .dlv_valid(dlv_valid), .dlv_ready(dlv_ready),
    .dlv_accepted(dlv_accepted), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_lvl(dlv_lvl), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_lvl(eoi_lvl),
    .remote_irr(remote_irr));

  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      dcnt[dlv_pin]++;
      lastvec[dlv_pin]  = dlv_vector;
      lastdest[dlv_pin] = dlv_dest;
      if (ord_n < 64) begin ord[ord_n] = dlv_pin; ord_n++; end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clr();
    for (int i = 0; i < NP; i++) begin dcnt[i] = 0; lastvec[i] = -1; lastdest[i] = -1; end
    ord_n = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; pin_level = '0; ent_mask = '1; eoi_valid = 0; eoi_vector = '0; eoi_lvl = 0;
    dlv_ready = 1; dlv_accepted = 1;
    tick(3);
    rst_n = 1;
    tick(1);
    clr();
  endtask

  task automatic eoi(input logic [7:0] v, input logic l);
    eoi_vector = v; eoi_lvl = l; eoi_valid = 1;
    tick(1);
    eoi_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    ent_vector = {8'h23, 8'h22, 8'h21, 8'h20};
    ent_dest   = {4'hB, 4'hA, 4'h9, 4'h8};
    ent_lvl    = 4'b0110;

    // R1 reset state
    do_reset();
    chk("R1 valid after reset", dlv_valid, 0);
    chk("R1 remote_irr after reset", remote_irr, 0);
    ent_mask = '0; tick(3);
    chk("R1 no spurious request", dcnt[0]+dcnt[1]+dcnt[2]+dcnt[3], 0);

    // R2 edge pin 0: one delivery per rise, coalesced while high
    pin_level[0] = 1; tick(3);
    chk("R2 edge delivery count", dcnt[0], 1);
    chk("R10 edge vector", lastvec[0], 'h20);
    chk("R10 edge dest", lastdest[0], 8);
    tick(10);
    chk("R2 held high coalesced", dcnt[0], 1);
    chk("R4 edge remote_irr zero", remote_irr[0], 0);
    pin_level[0] = 0; tick(2); pin_level[0] = 1; tick(3);
    chk("R2 second rise", dcnt[0], 2);

    // R3 masked edge pin 3, not retried on unmask
    ent_mask[3] = 1; pin_level[3] = 1; tick(3);
    chk("R3 masked edge", dcnt[3], 0);
    ent_mask[3] = 0; tick(5);
    chk("R3 no retry on unmask", dcnt[3], 0);
    pin_level[3] = 0; tick(2); pin_level[3] = 1; tick(3);
    chk("R3 new rise after unmask", dcnt[3], 1);

    // Level pin 1: remote-IRR gating and EOI
    do_reset(); ent_mask = '0;
    pin_level[1] = 1; tick(3);
    chk("R4 level delivered", dcnt[1], 1);
    chk("R4 remote_irr set", remote_irr[1], 1);
    tick(10);
    chk("R3 held level blocked", dcnt[1], 1);
    pin_level[1] = 0; tick(2); pin_level[1] = 1; tick(3);
    chk("R3 rise with remote_irr refused", dcnt[1], 1);
    eoi(8'h21, 0); tick(3);
    chk("R5 edge-type eoi ignored", remote_irr[1], 1);
    eoi(8'h22, 1); tick(3);
    chk("R5 other vector ignored", remote_irr[1], 1);
    chk("R5 other vector no delivery", dcnt[1], 1);
    eoi(8'h21, 1); tick(3);
    chk("R6 eoi re-service", dcnt[1], 2);
    chk("R6 remote_irr set again", remote_irr[1], 1);
    ent_mask[1] = 1; tick(1);
    eoi(8'h21, 1); tick(3);
    chk("R5 eoi clears while masked", remote_irr[1], 0);
    chk("R6 masked not re-served", dcnt[1], 2);
    ent_mask[1] = 0; tick(5);
    chk("R3 no retry after unmask", dcnt[1], 2);
    pin_level[1] = 0; tick(2); pin_level[1] = 1; tick(3);
    chk("R2 level new rise", dcnt[1], 3);

    // R4 not accepted
    do_reset(); ent_mask = '0; dlv_accepted = 0;
    pin_level[2] = 1; tick(3);
    chk("R4 not-accepted delivered", dcnt[2], 1);
    chk("R4 not-accepted remote_irr", remote_irr[2], 0);
    dlv_accepted = 1;

    // R7/R8 storm on pin 1
    do_reset(); ent_mask = '0;
    pin_level[1] = 1; tick(3);
    for (int k = 1; k < LIM; k++) begin
      eoi(8'h21, 1); tick(3);
      chk("R7 successive re-service", dcnt[1], 1 + k);
    end
    eoi(8'h21, 1); tick(DEF - 2);
    chk("R8 deferred no delivery", dcnt[1], LIM);
    chk("R8 remote_irr clear during deferral", remote_irr[1], 0);
    tick(4);
    chk("R8 delivery after deferral", dcnt[1], LIM + 1);
    chk("R8 remote_irr after deferral", remote_irr[1], 1);
    for (int k = 1; k < LIM; k++) begin eoi(8'h21, 1); tick(3); end
    chk("R7 count before mask", dcnt[1], 2*LIM);
    ent_mask[1] = 1; tick(2); ent_mask[1] = 0; tick(1);
    for (int k = 1; k < LIM; k++) begin eoi(8'h21, 1); tick(3); end
    chk("R7 counter cleared by mask", dcnt[1], 3*LIM - 1);

    // R9 expiry serves all qualifying level pins
    do_reset(); ent_mask = '0;
    dlv_accepted = 0; pin_level[2] = 1; tick(3); dlv_accepted = 1;
    pin_level[0] = 1; tick(3);
    pin_level[1] = 1; tick(3);
    for (int k = 0; k < LIM; k++) begin eoi(8'h21, 1); tick(3); end
    chk("R8 storm reached", dcnt[1], LIM);
    tick(DEF + 4);
    chk("R9 storm pin served at expiry", dcnt[1], LIM + 1);
    chk("R9 other level pin served", dcnt[2], 2);
    chk("R9 edge pin not served", dcnt[0], 1);

    // R9 masked at expiry
    do_reset(); ent_mask = '0;
    pin_level[1] = 1; tick(3);
    for (int k = 0; k < LIM; k++) begin eoi(8'h21, 1); tick(3); end
    ent_mask[1] = 1;
    tick(DEF + 4);
    chk("R9 masked pin not served", dcnt[1], LIM);
    ent_mask[1] = 0; tick(5);
    chk("R3 expiry attempt not retried", dcnt[1], LIM);

    // Same-cycle EOI and handshake of another pin
    do_reset(); ent_mask = '0;
    pin_level[1] = 1; tick(3);
    dlv_ready = 0; pin_level[2] = 1; tick(3);
    chk("R10 stalled valid", dlv_valid, 1);
    chk("R10 stalled pin", dlv_pin, 2);
    eoi_vector = 8'h21; eoi_lvl = 1; eoi_valid = 1; dlv_ready = 1;
    tick(1); eoi_valid = 0; tick(3);
    chk("R4 concurrent pin2 delivered", dcnt[2], 1);
    chk("R4 concurrent pin2 remote_irr", remote_irr[2], 1);
    chk("R6 concurrent pin1 re-served", dcnt[1], 2);
    chk("R5 concurrent pin1 remote_irr", remote_irr[1], 1);
    chk("R10 concurrent order", ord[ord_n-2]*10 + ord[ord_n-1], 21);

    // R10 priority sweep over every pin subset
    for (int m = 1; m < (1 << NP); m++) begin
      int low, pc;
      do_reset(); ent_mask = '0; dlv_ready = 0;
      low = -1; pc = 0;
      for (int i = NP - 1; i >= 0; i--) if (m[i]) begin low = i; pc++; end
      pin_level = NP'(m); tick(2);
      chk("R10 lowest pin first", dlv_pin, low);
      chk("R10 vector of selected", dlv_vector, 'h20 + low);
      dlv_ready = 1; tick(pc + 3);
      chk("R10 one per handshake", ord_n, pc);
      for (int j = 1; j < ord_n; j++)
        chk("R10 ascending order", ord[j] > ord[j-1], 1);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule